// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM with a 16-bit data bus and per-byte lane strobes. The host hands over a single transfer per handshake: an address, write data, a lane mask and a write flag. The controller then produces chip enable, output enable, write enable, lane strobes, the address and a driven data word as waveforms measured in whole clock cycles. For reads it captures the bus and returns the word with a one-cycle valid pulse.

Each phase of an access lasts a set number of cycles, and each phase length is its own parameter. The integrator works these out from the memory's speed grade and the clock period. For example, at the fastest grade with a 4 ns clock, a 55 ns write pulse or read access needs at least 14 access cycles, and 25 ns of data setup before the end of the write is met by the setup and access phases.

The state machine has five named states:

- **IDLE**: ready is high and the bus is quiet.
- **SETUP**: chip enable and the lane strobes are asserted around a stable address. Output enable goes low for a read, or the data driver turns on for a write.
- **ACCESS**: write enable is pulsed for a write, or the controller waits out the access time for a read.
- **HOLD**: write enable or output enable is released while the address and strobes stay put.
- **GAP**: the bus is fully idle, giving turnaround time.

The transitions are:

- IDLE→SETUP when a request is accepted.
- SETUP→ACCESS, ACCESS→HOLD, HOLD→GAP and GAP→IDLE, each when that state's cycle count runs out.

Top module: `sram_bus_ctrl`

## Requirements
- R1: During and right after reset, req_ready is 1, sram_ce_n, sram_oe_n and sram_we_n are 1, every sram_bs_n bit is 1, sram_dq_oe is 0 and rd_valid is 0.
- R2: req_ready is high only in IDLE, and a request is taken on an edge where req_valid and req_ready are both 1. Requests held back to back are accepted every SETUP_CYC+ACCESS_CYC+HOLD_CYC+GAP_CYC+1 cycles.
- R3: Whenever sram_ce_n is 0, sram_addr equals the accepted address and does not change.
- R4: For a write, sram_we_n goes low exactly SETUP_CYC cycles after the accepting edge and stays low for exactly ACCESS_CYC cycles. sram_oe_n stays 1 for the whole write.
- R5: While sram_ce_n is 0, sram_bs_n[i] is 0 exactly when req_mask[i] was 1, where lane i is data bits 8i+7..8i. A write with mask 00 changes no memory byte.
- R6: sram_dq_oe is 1 only during a write's SETUP, ACCESS and HOLD, and only when sram_oe_n is 1 in that cycle and the cycle before. While it is 1, sram_dq_out equals the accepted write data.
- R7: For a read, sram_oe_n is low for exactly SETUP_CYC+ACCESS_CYC cycles and sram_we_n stays 1. rd_valid is a one-cycle pulse that starts SETUP_CYC+ACCESS_CYC cycles after the accepting edge.
- R8: rd_data carries the bus value sampled on the last ACCESS cycle for lanes whose mask bit is 1, and zero for the other lanes. A read after a write returns the bytes written.
- R9: Between two accesses, sram_ce_n stays high for at least GAP_CYC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (17) | Word address |
| req_wdata | input | DATA_W (16) | Write data |
| req_mask | input | DATA_W/8 (2) | Lane enables, bit i = bits 8i+7..8i |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W (16) | Read data, disabled lanes zero |
| sram_addr | output | ADDR_W (17) | Memory address |
| sram_dq_out | output | DATA_W (16) | Data toward memory |
| sram_dq_oe | output | 1 | Data driver enable |
| sram_dq_in | input | DATA_W (16) | Data from memory |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_bs_n | output | DATA_W/8 (2) | Lane strobes, active low |

## Verification
The bench uses phase lengths that differ from one another, so an off-by-one in any single phase changes a measured edge position. It measures the write pulse width, the output-enable window and the rd_valid position. It also checks the spacing between back-to-back accepts, which exposes a skipped gap or a ready that rises early.

The bench watches the data driver against the output-enable history. A controller that turns its driver on in the same cycle output enable rises, or during a read, would fight the memory on the bus.

Partial and empty lane masks are written and read back through a behavioural memory that puts a non-zero filler on disabled lanes. This catches strobes that ignore the mask, a mask-00 write that still lands, and read data that leaks unselected lanes.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_ACCESS = 3'd2,
        ST_HOLD   = 3'd3,
        ST_GAP    = 3'd4
    } phase_e;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              write_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [LANES-1:0]  mask_in,
    output logic              write_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  mask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (load) begin
            write_q <= write_in;
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
            mask_q  <= mask_in;
        end
    end
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] masked;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[g*LANE_W +: LANE_W] = lane_en[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= masked;
            end
        end
    end

    // R7: the valid strobe never lasts more than one cycle
    p_rdvalid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 16,
    parameter int SETUP_CYC  = 1,
    parameter int ACCESS_CYC = 14,
    parameter int HOLD_CYC   = 1,
    parameter int GAP_CYC    = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W/8-1:0]      req_mask,
    output logic                     rd_valid,
    output logic [DATA_W-1:0]        rd_data,
    output logic [ADDR_W-1:0]        sram_addr,
    output logic [DATA_W-1:0]        sram_dq_out,
    output logic                     sram_dq_oe,
    input  logic [DATA_W-1:0]        sram_dq_in,
    output logic                     sram_ce_n,
    output logic                     sram_oe_n,
    output logic                     sram_we_n,
    output logic [DATA_W/8-1:0]      sram_bs_n
);
    localparam int LANES = DATA_W / 8;
    localparam int MAXC  = int'(max4(SETUP_CYC, ACCESS_CYC, HOLD_CYC, GAP_CYC));
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] ACCESS_LD = CNT_W'(ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD    = CNT_W'(GAP_CYC - 1);

    phase_e             state_q, state_d;
    logic               accept;
    logic               t_load, t_last;
    logic [CNT_W-1:0]   t_val;
    logic               wr_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [LANES-1:0]   mask_q;
    logic               capture;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    sram_req_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) i_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .write_in (req_write),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .mask_in  (req_mask),
        .write_q  (wr_q),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .mask_q   (mask_q)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    // next state and phase counter reload
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_SETUP;
                    t_load  = 1'b1;
                    t_val   = SETUP_LD;
                end
            end
            ST_SETUP: begin
                if (t_last) begin
                    state_d = ST_ACCESS;
                    t_load  = 1'b1;
                    t_val   = ACCESS_LD;
                end
            end
            ST_ACCESS: begin
                if (t_last) begin
                    state_d = ST_HOLD;
                    t_load  = 1'b1;
                    t_val   = HOLD_LD;
                end
            end
            ST_HOLD: begin
                if (t_last) begin
                    state_d = ST_GAP;
                    t_load  = 1'b1;
                    t_val   = GAP_LD;
                end
            end
            ST_GAP: begin
                if (t_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // pin decode
    always_comb begin
        sram_ce_n  = 1'b1;
        sram_oe_n  = 1'b1;
        sram_we_n  = 1'b1;
        sram_bs_n  = '1;
        sram_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_GAP: begin
            end
            ST_SETUP: begin
                sram_ce_n  = 1'b0;
                sram_bs_n  = ~mask_q;
                sram_oe_n  = wr_q;
                sram_dq_oe = wr_q;
            end
            ST_ACCESS: begin
                sram_ce_n  = 1'b0;
                sram_bs_n  = ~mask_q;
                sram_oe_n  = wr_q;
                sram_we_n  = ~wr_q;
                sram_dq_oe = wr_q;
            end
            ST_HOLD: begin
                sram_ce_n  = 1'b0;
                sram_bs_n  = ~mask_q;
                sram_dq_oe = wr_q;
            end
            default: begin
            end
        endcase
    end

    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;
    assign capture     = (state_q == ST_ACCESS) && t_last && !wr_q;

    sram_read_capture #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .lane_en  (mask_q),
        .bus_in   (sram_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // R4: write enable never overlaps output enable
    p_we_oe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);

    // R6: data driver only after output enable has been high for a cycle
    p_drive_after_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (sram_oe_n && $past(sram_oe_n)));

    // R3: address steady while the chip stays selected
    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    // R2: ready only with the bus deselected
    p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> sram_ce_n);

    // R5: strobes follow the accepted mask during the write pulse
    p_strobe_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && (sram_bs_n == ~mask_q)));

endmodule

// File: tb/test_sram_bus_ctrl.sv
module test_sram_bus_ctrl;
    localparam int AW = 17;
    localparam int DW = 16;
    localparam int S  = 2;
    localparam int A  = 3;
    localparam int H  = 1;
    localparam int G  = 2;
    localparam int PERIOD = S + A + H + G + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0] req_mask = '0;
    logic req_ready, rd_valid, sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n;
    logic [DW-1:0] rd_data, sram_dq_out, sram_dq_in;
    logic [AW-1:0] sram_addr;
    logic [1:0] sram_bs_n;

    always #2 clk = ~clk;

    sram_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .ACCESS_CYC(A),
                    .HOLD_CYC(H), .GAP_CYC(G)) i_sram_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_bs_n(sram_bs_n));

    int checks = 0, fails = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // behavioural memory
    logic [DW-1:0] mem [16];
    logic [DW-1:0] exp_mem [16];
    always @(posedge sram_we_n) begin
        if (sram_ce_n === 1'b0) begin
            for (int l = 0; l < 2; l++)
                if (!sram_bs_n[l]) mem[sram_addr[3:0]][l*8 +: 8] = sram_dq_out[l*8 +: 8];
        end
    end
    always_comb begin
        sram_dq_in = 16'hA5A5;
        if (sram_ce_n === 1'b0 && sram_oe_n === 1'b0)
            for (int l = 0; l < 2; l++)
                if (!sram_bs_n[l]) sram_dq_in[l*8 +: 8] = mem[sram_addr[3:0]][l*8 +: 8];
    end

    always @(posedge clk) cyc <= cyc + 1;

    // driver state shared with the monitor
    logic [AW-1:0] cur_addr = '0;
    logic [DW-1:0] cur_wdata = '0;
    logic [1:0] cur_mask = '0;
    bit cur_write = 0;
    int acc_cyc = -1000;
    int prev_acc = -1000;
    bit b2b = 0;
    logic [DW-1:0] rq[$];

    task automatic do_access(input bit wr, input logic [AW-1:0] ad,
                             input logic [1:0] mk, input logic [DW-1:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = ad; req_mask = mk; req_wdata = wd;
        while (req_ready !== 1'b1) @(negedge clk);
        cur_addr = ad; cur_mask = mk; cur_wdata = wd; cur_write = wr;
        prev_acc = acc_cyc;
        acc_cyc = cyc + 1;
        if (b2b) chk(acc_cyc - prev_acc == PERIOD, "R2 back-to-back spacing", acc_cyc - prev_acc, PERIOD);
        if (wr) begin
            for (int l = 0; l < 2; l++)
                if (mk[l]) exp_mem[ad[3:0]][l*8 +: 8] = wd[l*8 +: 8];
        end else begin
            logic [DW-1:0] e;
            for (int l = 0; l < 2; l++) e[l*8 +: 8] = mk[l] ? exp_mem[ad[3:0]][l*8 +: 8] : 8'h00;
            rq.push_back(e);
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // monitor
    logic p_we = 1, p_oe = 1, p_ce = 1;
    int we_low = 0, oe_low = 0, ce_high = 0;
    bit seen_access = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int d;
            d = cyc - acc_cyc;
            if (d >= 0 && d <= PERIOD - 1)
                chk(req_ready == (d >= PERIOD - 1), "R2 ready", req_ready, d >= PERIOD - 1);
            if (!sram_ce_n) begin
                chk(sram_addr == cur_addr, "R3 address", sram_addr, cur_addr);
                chk(sram_bs_n == ~cur_mask, "R5 strobes", sram_bs_n, ~cur_mask);
            end
            if (sram_dq_oe) begin
                chk(cur_write && sram_oe_n && p_oe, "R6 driver vs oe", {sram_oe_n, p_oe}, 3);
                chk(sram_dq_out == cur_wdata, "R6 drive data", sram_dq_out, cur_wdata);
            end
            if (!sram_we_n) begin
                chk(sram_oe_n, "R4 oe high during write", sram_oe_n, 1);
                if (p_we) chk(d == S, "R4 we fall position", d, S);
                we_low++;
            end else if (!p_we) begin
                chk(we_low == A, "R4 we width", we_low, A);
                we_low = 0;
            end
            if (!sram_oe_n) begin
                chk(sram_we_n && !cur_write, "R7 oe only on reads", sram_we_n, 1);
                oe_low++;
            end else if (!p_oe) begin
                chk(oe_low == S + A, "R7 oe width", oe_low, S + A);
                oe_low = 0;
            end
            if (sram_ce_n) ce_high++;
            else begin
                if (p_ce && seen_access) chk(ce_high >= G + 1, "R9 idle gap", ce_high, G + 1);
                ce_high = 0;
                seen_access = 1;
            end
            if (rd_valid) begin
                chk(d == S + A, "R7 rd_valid position", d, S + A);
                if (rq.size() == 0) chk(0, "R8 unexpected rd_valid", 1, 0);
                else begin
                    logic [DW-1:0] e;
                    e = rq.pop_front();
                    chk(rd_data == e, "R8 read data", rd_data, e);
                end
            end
            p_we = sram_we_n; p_oe = sram_oe_n; p_ce = sram_ce_n;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #200000;
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin mem[i] = 16'h0000; exp_mem[i] = 16'h0000; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1, "R1 ready", req_ready, 1);
        chk({sram_ce_n, sram_oe_n, sram_we_n} === 3'b111, "R1 controls", {sram_ce_n, sram_oe_n, sram_we_n}, 7);
        chk(sram_bs_n === 2'b11, "R1 strobes", sram_bs_n, 3);
        chk(sram_dq_oe === 1'b0 && rd_valid === 1'b0, "R1 driver and valid", {sram_dq_oe, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && sram_ce_n === 1'b1, "R1 after release", {req_ready, sram_ce_n}, 3);
        // full, lower, upper and empty masks (R5, R8)
        do_access(1, 17'd3, 2'b11, 16'h1234);
        do_access(0, 17'd3, 2'b11, 16'h0);
        do_access(1, 17'd5, 2'b11, 16'hFFFF);
        do_access(1, 17'd5, 2'b01, 16'hAB12);
        do_access(0, 17'd5, 2'b11, 16'h0);
        do_access(1, 17'd6, 2'b10, 16'hC3EE);
        do_access(0, 17'd6, 2'b11, 16'h0);
        do_access(1, 17'd3, 2'b00, 16'h9999);
        do_access(0, 17'd3, 2'b11, 16'h0);
        // partial-lane reads: unselected lanes must be zero (R8)
        do_access(0, 17'd5, 2'b10, 16'h0);
        do_access(0, 17'd5, 2'b01, 16'h0);
        // back-to-back mixed traffic (R2, R9)
        b2b = 1;
        do_access(1, 17'd9, 2'b11, 16'h5A5A);
        do_access(0, 17'd9, 2'b11, 16'h0);
        do_access(1, 17'd10, 2'b11, 16'h0F0F);
        do_access(1, 17'd11, 2'b11, 16'h7777);
        do_access(0, 17'd10, 2'b11, 16'h0);
        do_access(0, 17'd11, 2'b11, 16'h0);
        b2b = 0;
        repeat (PERIOD + 4) @(negedge clk);
        chk(rq.size() == 0, "R8 all reads returned", rq.size(), 0);
        chk(req_ready === 1'b1 && sram_ce_n === 1'b1, "R2 idle at end", {req_ready, sram_ce_n}, 3);
        finish_run();
    end
endmodule